// File: doc/BRIEF.md
# Eight-Source Vectored Interrupt Controller

This block takes eight interrupt requests and reports at most one of them to the CPU sequencer. The eight requests are four active-low external pins, overflow events from two timers, a level flag from a third timer and a level flag from the serial port. Each request is gated by its own enable bit and by a global enable bit. The pending request with the lowest index wins a fixed polling order. The block raises `irq` and drives the 8-bit entry address of the winning source on `vec`.

The `irq`/`ack` pair works as a valid/ready handshake. While `irq` is high, `irq` and `vec` stay frozen until the sequencer pulses `ack`. A request that appears during that time, even one of higher rank, waits. The vector is taken on the clock edge where `irq` and `ack` are both high. On that edge `irq` falls, and the latched flag of the taken source is cleared if that source has one. Arbitration runs again on the following edge. An `ack` while `irq` is low has no effect.

Each external pin has a type bit. In edge mode a falling edge sets a latched flag. In level mode the request is simply a registered low pin. The two timer overflow pulses set latched flags. The third timer flag and the serial flag pass straight through and are cleared by software at their origin.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq` is 0 and `vec` is 8'h00. `vec` reads 8'h00 whenever `irq` is 0.
- R2: Source indices and fixed rank, with index 0 highest: 0 = external pin 0, 1 = timer 0 overflow, 2 = external pin 1, 3 = timer 1 overflow, 4 = serial flag, 5 = timer 2 flag, 6 = external pin 2, 7 = external pin 3. Among the pending, enabled sources, the lowest index is presented.
- R3: When source i is presented, `vec` equals 8*i + 3, giving 8'h03, 8'h0B, 8'h13, 8'h1B, 8'h23, 8'h2B, 8'h33 and 8'h3B.
- R4: `ie[5:0]` enables sources 0 to 5 in that bit order. `ext_en[0]` enables source 6 and `ext_en[1]` enables source 7. A pending source whose bit is 0 never raises `irq`.
- R5: While `ie[7]` is 0, `irq` does not rise, whatever is pending.
- R6: An external pin whose `ext_edge` bit is 1 latches a request on a high-to-low transition. The request stays after the pin returns high, and it clears when its vector is taken.
- R7: An external pin whose `ext_edge` bit is 0 requests while it is sampled low. Taking its vector does not clear it, and a pin that is high again no longer requests.
- R8: A one-cycle pulse on `tmr_ovf[0]` or `tmr_ovf[1]` sets a latched flag for source 1 or source 3 respectively. The flag clears when that vector is taken.
- R9: `ser_req` and `tmr2_req` request while they are high. Taking their vector does not clear them.
- R10: While `irq` is high and `ack` is low, on the next cycle `irq` stays high and `vec` is unchanged. An `ack` with `irq` high drops `irq` on the next cycle.
- R11: Taking a vector clears only the flag of the presented source. Other latched flags remain and are presented afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_n | input | 4 | External request pins, active low; bit k is external pin k |
| ext_edge | input | 4 | Per-pin sensing type: 1 = falling edge, 0 = low level |
| tmr_ovf | input | 2 | Overflow pulses of timer 0 (bit 0) and timer 1 (bit 1) |
| tmr2_req | input | 1 | Timer 2 level flag |
| ser_req | input | 1 | Serial port level flag |
| ie | input | 8 | Bits 5:0 enable sources 5:0; bit 7 is the global enable |
| ext_en | input | 2 | Enables for external pins 2 and 3 |
| ack | input | 1 | Vector taken strobe from the sequencer |
| irq | output | 1 | Interrupt request (valid) |
| vec | output | 8 | Entry address of the presented source |

## Verification
Each source is raised alone to confirm its vector address. Sources are also stacked three deep and served one at a time to show the ranking. Edge-mode and level-mode pins get the same pulse-then-release pattern, and only the edge case may keep requesting once the pin is back high. Taking a vector then separates the cleared flags from the level requests that must reappear. A higher-ranked request raised during a pending one shows that the presented vector is held. A pair of latched flags shows that taking one vector leaves the other flag set.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
  localparam int NSRC    = 8;
  localparam int IDX_W   = $clog2(NSRC);
  localparam int VEC_W   = 8;
  localparam int NEXT    = 4;
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;

  typedef logic [IDX_W-1:0] src_idx_t;
  typedef logic [VEC_W-1:0] vec_t;

  // polling position of each external pin
  function automatic int ext_slot(input int k);
    case (k)
      0: return 0;
      1: return 2;
      2: return 6;
      default: return 7;
    endcase
  endfunction

  function automatic vec_t vec_of(input src_idx_t idx);
    return vec_t'(VEC_BASE + VEC_STEP * int'(idx));
  endfunction
endpackage

// File: rtl/irq_ext_sense.sv
module irq_ext_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic smp_now, smp_prev, edge_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_now   <= 1'b1;
      smp_prev  <= 1'b1;
      edge_flag <= 1'b0;
    end else begin
      smp_now  <= pin_n;
      smp_prev <= smp_now;
      if (!edge_mode)
        edge_flag <= 1'b0;
      else if (smp_prev && !smp_now)
        edge_flag <= 1'b1;
      else if (clr)
        edge_flag <= 1'b0;
    end
  end

  assign req = edge_mode ? edge_flag : ~smp_now;
endmodule

// File: rtl/irq_flag_latch.sv
module irq_flag_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] pend,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = N-1; i >= 0; i--)
      if (pend[i]) idx = W'(i);
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEXT-1:0] ext_n,
  input  logic [NEXT-1:0] ext_edge,
  input  logic [1:0]      tmr_ovf,
  input  logic            tmr2_req,
  input  logic            ser_req,
  input  logic [7:0]      ie,
  input  logic [1:0]      ext_en,
  input  logic            ack,
  output logic            irq,
  output logic [VEC_W-1:0] vec
);
  logic [NSRC-1:0] raw, gate, pend, clr_vec;
  logic [NEXT-1:0] ext_req;
  logic [1:0]      tmr_flag;
  logic            any;
  src_idx_t        pick, sel_q;
  logic            irq_q;
  logic            take;

  assign take    = irq_q & ack;
  assign clr_vec = take ? (NSRC'(1) << sel_q) : '0;

  for (genvar k = 0; k < NEXT; k++) begin : g_ext
    irq_ext_sense u_sense (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_n     (ext_n[k]),
      .edge_mode (ext_edge[k]),
      .clr       (clr_vec[ext_slot(k)]),
      .req       (ext_req[k])
    );
  end

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    irq_flag_latch u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (tmr_ovf[t]),
      .clr   (clr_vec[2*t+1]),
      .flag  (tmr_flag[t])
    );
  end

  assign raw  = {ext_req[3], ext_req[2], tmr2_req, ser_req,
                 tmr_flag[1], ext_req[1], tmr_flag[0], ext_req[0]};
  assign gate = {ext_en, ie[5:0]} & {NSRC{ie[7]}};
  assign pend = raw & gate;

  irq_prio_pick #(.N(NSRC)) u_pick (
    .pend (pend),
    .any  (any),
    .idx  (pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      sel_q <= '0;
    end else if (irq_q) begin
      if (ack) irq_q <= 1'b0;
    end else if (any) begin
      irq_q <= 1'b1;
      sel_q <= pick;
    end
  end

  assign irq = irq_q;
  assign vec = irq_q ? vec_of(sel_q) : '0;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ie,
  input logic       ack,
  input logic       irq,
  input logic [7:0] vec
);
  // R10: presented request frozen until taken
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack |=> irq && $stable(vec));
  // R10: taking the vector drops the request
  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq && ack |=> !irq);
  // R3: address format 8*i+3
  p_vec_fmt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> vec[2:0] == 3'b011 && vec[7:6] == 2'b00);
  // R5: global enable low keeps request down
  p_global_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ie[7] && !irq |=> !irq);
  // R1: idle vector reads zero
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> vec == 8'h00);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ie    (ie),
  .ack   (ack),
  .irq   (irq),
  .vec   (vec)
);

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext_n = 4'hF;
  logic [3:0] ext_edge = 4'h0;
  logic [1:0] tmr_ovf = 2'b00;
  logic       tmr2_req = 1'b0;
  logic       ser_req = 1'b0;
  logic [7:0] ie = 8'hBF;
  logic [1:0] ext_en = 2'b11;
  logic       ack = 1'b0;
  logic       irq;
  logic [7:0] vec;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .ext_edge(ext_edge),
    .tmr_ovf(tmr_ovf), .tmr2_req(tmr2_req), .ser_req(ser_req),
    .ie(ie), .ext_en(ext_en), .ack(ack), .irq(irq), .vec(vec)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic take();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic t_reset();
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 vec", vec, 8'h00);
  endtask

  task automatic t_each_vector();
    for (int i = 0; i < 8; i++) begin
      case (i)
        0: ext_n[0] = 1'b0;
        1: tmr_ovf[0] = 1'b1;
        2: ext_n[1] = 1'b0;
        3: tmr_ovf[1] = 1'b1;
        4: ser_req = 1'b1;
        5: tmr2_req = 1'b1;
        6: ext_n[2] = 1'b0;
        default: ext_n[3] = 1'b0;
      endcase
      @(negedge clk);
      tmr_ovf = 2'b00;
      cyc(3);
      chk("R3 vector", vec, 8'(8*i + 3));
      ext_n = 4'hF; ser_req = 1'b0; tmr2_req = 1'b0;
      cyc(3);
      take();
      cyc(3);
      chk("R3 cleared", {7'd0, irq}, 8'h00);
    end
  endtask

  task automatic t_priority();
    ser_req = 1'b1; tmr2_req = 1'b1; ext_n[3] = 1'b0;
    cyc(4);
    chk("R2 first", vec, 8'h23);
    ser_req = 1'b0;
    take();
    cyc(2);
    chk("R2 second", vec, 8'h2B);
    tmr2_req = 1'b0;
    take();
    cyc(2);
    chk("R2 third", vec, 8'h3B);
    ext_n[3] = 1'b1;
    cyc(3);
    take();
    cyc(3);
    chk("R2 idle", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_hold();
    ext_n[3] = 1'b0;
    cyc(4);
    ext_n[0] = 1'b0;
    cyc(4);
    chk("R10 held", vec, 8'h3B);
    chk("R10 irq", {7'd0, irq}, 8'h01);
    ext_n[3] = 1'b1;
    take();
    chk("R10 dropped", {7'd0, irq}, 8'h00);
    cyc(1);
    chk("R10 rearb", vec, 8'h03);
    ext_n[0] = 1'b1;
    cyc(3);
    take();
    cyc(3);
  endtask

  task automatic t_enables();
    ie = 8'h80 | 8'h2F;
    ser_req = 1'b1;
    cyc(5);
    chk("R4 ser masked", {7'd0, irq}, 8'h00);
    ser_req = 1'b0;
    ie = 8'hBF; ext_en = 2'b10;
    ext_n[2] = 1'b0;
    cyc(5);
    chk("R4 ext2 masked", {7'd0, irq}, 8'h00);
    ext_en = 2'b11;
    cyc(3);
    chk("R4 ext2 enabled", vec, 8'h33);
    ext_n[2] = 1'b1;
    cyc(3);
    take();
    cyc(3);
  endtask

  task automatic t_global();
    ie = 8'h3F;
    ser_req = 1'b1;
    cyc(5);
    chk("R5 blocked", {7'd0, irq}, 8'h00);
    ie = 8'hBF;
    cyc(2);
    chk("R5 open", vec, 8'h23);
    ser_req = 1'b0;
    take();
    cyc(3);
  endtask

  task automatic t_edge();
    ext_edge[0] = 1'b1;
    cyc(2);
    ext_n[0] = 1'b0;
    cyc(2);
    ext_n[0] = 1'b1;
    cyc(4);
    chk("R6 latched", vec, 8'h03);
    take();
    cyc(3);
    chk("R6 cleared", {7'd0, irq}, 8'h00);
    ext_edge[0] = 1'b0;
    cyc(2);
  endtask

  task automatic t_level();
    ext_n[1] = 1'b0;
    cyc(4);
    chk("R7 level", vec, 8'h13);
    take();
    cyc(2);
    chk("R7 persists", vec, 8'h13);
    ext_n[1] = 1'b1;
    cyc(3);
    take();
    cyc(3);
    chk("R7 released", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_timers_pass();
    tmr_ovf[1] = 1'b1;
    @(negedge clk);
    tmr_ovf = 2'b00;
    cyc(3);
    chk("R8 tmr1", vec, 8'h1B);
    take();
    cyc(3);
    chk("R8 cleared", {7'd0, irq}, 8'h00);
    tmr2_req = 1'b1;
    cyc(3);
    chk("R9 tmr2", vec, 8'h2B);
    take();
    cyc(2);
    chk("R9 stays", vec, 8'h2B);
    tmr2_req = 1'b0;
    take();
    cyc(3);
    chk("R9 released", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_other_flag();
    ie = 8'h3F;
    ext_edge[1] = 1'b1;
    cyc(2);
    ext_n[1] = 1'b0;
    tmr_ovf[1] = 1'b1;
    @(negedge clk);
    tmr_ovf = 2'b00;
    ext_n[1] = 1'b1;
    cyc(4);
    ie = 8'hBF;
    cyc(2);
    chk("R11 first", vec, 8'h13);
    take();
    cyc(2);
    chk("R11 kept", vec, 8'h1B);
    take();
    cyc(3);
    chk("R11 empty", {7'd0, irq}, 8'h00);
    ext_edge[1] = 1'b0;
  endtask

  initial begin
    #50000;
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_each_vector();
    t_priority();
    t_hold();
    t_enables();
    t_global();
    t_edge();
    t_level();
    t_timers_pass();
    t_other_flag();
    report();
  end
endmodule